// File: doc/BRIEF.md
# Track Packet Queue and Bit Streamer

This block sits between a command decoder and a track waveform generator. The decoder hands it track packets as a stream of 7-bit groups, with a flag on the final group of each packet. The block checks each packet, keeps up to three complete packets in arrival order, and gives them out one bit per request from the waveform generator, most significant bit first. When nothing is queued it supplies a fixed idle pattern instead, so the track always has a bit to send.

Each time the last bit of a packet has been taken, the block raises a done message. That message carries how many complete packets are still waiting. The decoder uses it to pace further packets. Packets that are too short, too long or lack the all-ones lead-in are dropped and flagged.

The group input uses valid/ready. A group is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while three complete packets are outstanding, and the sender must then hold its group stable. The done output also uses valid/ready. Once raised, a done message holds until `done_ready` is seen high. If another packet finishes first, the newer message replaces the older one. The bit side has no back-pressure: `bit_data` is always meaningful, and `bit_take` advances it.

Top module: `tpq_streamer`

## Requirements
- R1: Group k of a packet (k from 0) fills packet bits 7k to 7k+6, with bit 6 of `in_group` first, and `in_last` marks the final group.
- R2: `bit_data` shows the current bit, and each cycle with `bit_take` high moves to the next; a packet of n groups yields exactly 7n bits.
- R3: A packet with fewer than 2 groups, or with a 0 in any of its first 14 bits, is discarded; `pkt_err` is high for one cycle, the cycle after its last group is accepted.
- R4: A packet of more than 15 groups is discarded, with the same one-cycle `pkt_err` pulse after its last group.
- R5: At most 3 complete packets are outstanding (queued or being sent); `in_ready` is low exactly while 3 are outstanding, and a packet frees its place once its last bit is taken.
- R6: Packets are sent whole, in the order their last groups were accepted.
- R7: With no packet outstanding, the output is the 20-bit idle pattern 0xFFFC0 (14 ones then 6 zeros), MSB first, repeated; after reset `bit_data` shows its first bit.
- R8: An idle pattern whose first bit has been taken is always sent in full before a packet starts; the choice between packet and idle is made only at a pattern or packet boundary.
- R9: The cycle after a packet's last bit is taken, `done_valid` is high and `done_count` equals the number of complete packets still outstanding at that point. The message holds until `done_ready`, and a newer message replaces it.
- R10: After reset `in_ready` is 1, `done_valid` is 0 and `pkt_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Block can accept a group |
| in_group | input | 7 | Seven packet bits, bit 6 first |
| in_last | input | 1 | Group ends its packet |
| pkt_err | output | 1 | Pulse: last packet was discarded |
| bit_take | input | 1 | Waveform generator consumes the current bit |
| bit_data | output | 1 | Current track bit |
| done_valid | output | 1 | Done message pending |
| done_ready | input | 1 | Done message accepted |
| done_count | output | 2 | Complete packets still outstanding |

## Verification
The bit stream is driven in three patterns: a request every cycle, a request every third cycle, and a long pause in the middle of a packet. The every-cycle pattern exposes off-by-one errors in packet length and at idle boundaries. The slow pattern fills the queue, which tests back-pressure and order. The pause shows that bits hold without being lost or skipped.

Packets of 2, 3, 5 and 15 groups are mixed with bad ones. These cover a broken lead-in, a single group and sixteen groups. They separate length handling from lead-in checking. A phase with `done_ready` held low separates holding the done message from replacing it.

// File: rtl/tpq_pkg.sv
`timescale 1ns/1ps
package tpq_pkg;
  typedef enum logic [1:0] {ST_GAP, ST_IDLE, ST_PKT} strm_e;
endpackage

// File: rtl/tpq_asm.sv
`timescale 1ns/1ps
module tpq_asm #(
  parameter int GRP_W    = 7,
  parameter int MAX_GRPS = 15,
  parameter int PRE_ONES = 14,
  parameter int GI_W     = 4,
  parameter int LEN_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [GRP_W-1:0] grp,
  input  logic             last,
  output logic             wr_en,
  output logic [GI_W-1:0]  wr_grp,
  output logic             commit,
  output logic [LEN_W-1:0] commit_len,
  output logic             pkt_err
);
  logic [GI_W-1:0] gidx;
  logic            bad;
  logic            in_range, grp_bad, short_pkt, final_bad;

  always_comb begin
    grp_bad = 1'b0;
    for (int j = 0; j < GRP_W; j++) begin
      if ((int'(gidx) * GRP_W + j) < PRE_ONES && !grp[GRP_W-1-j]) grp_bad = 1'b1;
    end
    in_range   = int'(gidx) < MAX_GRPS;
    short_pkt  = ((int'(gidx) + 1) * GRP_W) < PRE_ONES;
    final_bad  = bad | ~in_range | grp_bad | short_pkt;
    wr_en      = fire & in_range;
    wr_grp     = gidx;
    commit     = fire & last & ~final_bad;
    commit_len = LEN_W'((int'(gidx) + 1) * GRP_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gidx    <= '0;
      bad     <= 1'b0;
      pkt_err <= 1'b0;
    end else begin
      pkt_err <= fire & last & final_bad;
      if (fire) begin
        if (last) begin
          gidx <= '0;
          bad  <= 1'b0;
        end else begin
          if (in_range) gidx <= gidx + 1'b1;
          bad <= bad | ~in_range | grp_bad;
        end
      end
    end
  end

  a_r4_gidx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gidx) <= MAX_GRPS);
  a_r3_err_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && final_bad) |=> pkt_err);
endmodule

// File: rtl/tpq_slots.sv
`timescale 1ns/1ps
module tpq_slots #(
  parameter int SLOTS    = 3,
  parameter int PKT_BITS = 105,
  parameter int GRP_W    = 7,
  parameter int GI_W     = 4,
  parameter int LEN_W    = 7,
  parameter int PTR_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PTR_W-1:0]    wr_slot,
  input  logic [GI_W-1:0]     wr_grp,
  input  logic [GRP_W-1:0]    wr_data,
  input  logic                len_en,
  input  logic [LEN_W-1:0]    len_data,
  input  logic [PTR_W-1:0]    rd_slot,
  output logic [PKT_BITS-1:0] rd_data,
  output logic [LEN_W-1:0]    rd_len
);
  localparam int BI_W = $clog2(PKT_BITS);

  logic [PKT_BITS-1:0] data_q [SLOTS];
  logic [LEN_W-1:0]    len_q  [SLOTS];
  logic [BI_W-1:0]     wr_top;

  always_comb wr_top = BI_W'(PKT_BITS - 1 - GRP_W * int'(wr_grp));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == PTR_W'(s)) data_q[s][wr_top -: GRP_W] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           len_q[s] <= '0;
      else if (len_en && wr_slot == PTR_W'(s)) len_q[s] <= len_data;
    end
  end

  assign rd_data = data_q[rd_slot];
  assign rd_len  = len_q[rd_slot];
endmodule

// File: rtl/tpq_qctl.sv
`timescale 1ns/1ps
module tpq_qctl #(
  parameter int SLOTS = 3,
  parameter int CNT_W = 2,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             pop,
  input  logic             done_ready,
  output logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             done_valid,
  output logic [CNT_W-1:0] done_count
);
  logic [CNT_W-1:0] cnt_nx;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb cnt_nx = cnt + CNT_W'(commit) - CNT_W'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      done_valid <= 1'b0;
      done_count <= '0;
    end else begin
      cnt <= cnt_nx;
      if (commit) wr_ptr <= step_ptr(wr_ptr);
      if (pop)    rd_ptr <= step_ptr(rd_ptr);
      if (pop) begin
        done_valid <= 1'b1;
        done_count <= cnt_nx;
      end else if (done_ready) begin
        done_valid <= 1'b0;
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(SLOTS)) |-> !commit);
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
  a_r9_pop_done: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> done_valid);
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready && !pop) |=> (done_valid && $stable(done_count)));
endmodule

// File: rtl/tpq_shift.sv
`timescale 1ns/1ps
module tpq_shift
  import tpq_pkg::*;
#(
  parameter int              PKT_BITS = 105,
  parameter int              LEN_W    = 7,
  parameter int              IDLE_LEN = 20,
  parameter logic [IDLE_LEN-1:0] IDLE_PAT = 20'hFFFC0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                have_pkt,
  input  logic [PKT_BITS-1:0] head_data,
  input  logic [LEN_W-1:0]    head_len,
  output logic                bit_data,
  output logic                pop
);
  localparam int IMAX = (PKT_BITS > IDLE_LEN) ? PKT_BITS : IDLE_LEN;
  localparam int IW   = $clog2(IMAX);

  strm_e          st;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  pk_sel, id_sel;
  logic           last_bit;

  always_comb begin
    pk_sel   = IW'(PKT_BITS - 1) - idx;
    id_sel   = IW'(IDLE_LEN - 1) - idx;
    last_bit = (st == ST_PKT) ? ((int'(idx) + 1) == int'(head_len))
                              : (int'(idx) == IDLE_LEN - 1);
    case (st)
      ST_IDLE: bit_data = IDLE_PAT[id_sel];
      ST_PKT:  bit_data = head_data[pk_sel];
      default: bit_data = have_pkt ? head_data[PKT_BITS-1] : IDLE_PAT[IDLE_LEN-1];
    endcase
    pop = take && (st == ST_PKT) && last_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_GAP;
      idx <= '0;
    end else if (take) begin
      if (st == ST_GAP) begin
        st  <= have_pkt ? ST_PKT : ST_IDLE;
        idx <= IW'(1);
      end else if (last_bit) begin
        st  <= ST_GAP;
        idx <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  a_r2_idx_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PKT) |-> (int'(idx) < int'(head_len)));
  a_r8_idle_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && take && !last_bit) |=> (st == ST_IDLE));
endmodule

// File: rtl/tpq_streamer.sv
`timescale 1ns/1ps
module tpq_streamer #(
  parameter int GRP_W    = 7,
  parameter int MAX_GRPS = 15,
  parameter int SLOTS    = 3,
  parameter int PRE_ONES = 14,
  parameter int IDLE_LEN = 20,
  parameter logic [IDLE_LEN-1:0] IDLE_PAT = 20'hFFFC0,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [GRP_W-1:0] in_group,
  input  logic             in_last,
  output logic             pkt_err,
  input  logic             bit_take,
  output logic             bit_data,
  output logic             done_valid,
  input  logic             done_ready,
  output logic [CNT_W-1:0] done_count
);
  localparam int PKT_BITS = GRP_W * MAX_GRPS;
  localparam int GI_W     = $clog2(MAX_GRPS + 1);
  localparam int LEN_W    = $clog2(PKT_BITS + 1);
  localparam int PTR_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic                fire, wr_en, commit, pop;
  logic [GI_W-1:0]     wr_grp;
  logic [LEN_W-1:0]    commit_len, head_len;
  logic [PKT_BITS-1:0] head_data;
  logic [CNT_W-1:0]    cnt;
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;

  assign in_ready = cnt < CNT_W'(SLOTS);
  assign fire     = in_valid & in_ready;

  tpq_asm #(.GRP_W(GRP_W), .MAX_GRPS(MAX_GRPS), .PRE_ONES(PRE_ONES),
            .GI_W(GI_W), .LEN_W(LEN_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .grp(in_group), .last(in_last),
    .wr_en(wr_en), .wr_grp(wr_grp), .commit(commit), .commit_len(commit_len),
    .pkt_err(pkt_err));

  tpq_slots #(.SLOTS(SLOTS), .PKT_BITS(PKT_BITS), .GRP_W(GRP_W), .GI_W(GI_W),
              .LEN_W(LEN_W), .PTR_W(PTR_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_ptr), .wr_grp(wr_grp),
    .wr_data(in_group), .len_en(commit), .len_data(commit_len),
    .rd_slot(rd_ptr), .rd_data(head_data), .rd_len(head_len));

  tpq_qctl #(.SLOTS(SLOTS), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_qctl (
    .clk(clk), .rst_n(rst_n), .commit(commit), .pop(pop), .done_ready(done_ready),
    .cnt(cnt), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .done_valid(done_valid), .done_count(done_count));

  tpq_shift #(.PKT_BITS(PKT_BITS), .LEN_W(LEN_W), .IDLE_LEN(IDLE_LEN),
              .IDLE_PAT(IDLE_PAT)) u_shift (
    .clk(clk), .rst_n(rst_n), .take(bit_take), .have_pkt(cnt != '0),
    .head_data(head_data), .head_len(head_len), .bit_data(bit_data), .pop(pop));
endmodule

// File: tb/test_tpq_streamer.sv
`timescale 1ns/1ps
module test_tpq_streamer;
  localparam logic [19:0] IDLE = 20'hFFFC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, bit_take = 1'b0, done_ready = 1'b1;
  logic [6:0] in_group = '0;
  logic in_ready, pkt_err, bit_data, done_valid;
  logic [1:0] done_count;

  always #2.5 clk = ~clk;

  tpq_streamer i_tpq_streamer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_group(in_group), .in_last(in_last), .pkt_err(pkt_err),
    .bit_take(bit_take), .bit_data(bit_data), .done_valid(done_valid),
    .done_ready(done_ready), .done_count(done_count));

  int total = 0, bad = 0;
  int errs_seen = 0;
  bit saw_full = 0, started = 0;
  int take_mode = 0, tk_cnt = 0;

  // behavioural reference model
  logic [104:0] mq_d[$];
  int           mq_l[$];
  logic [104:0] acur;
  int           ag, mst, midx, mdc;
  bit           abad, mdv, merr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_d.delete(); mq_l.delete();
      acur = '0; ag = 0; abad = 0; mst = 0; midx = 0; mdv = 0; mdc = 0; merr = 0;
    end else begin
      int sz;
      bit fire, popped, ok;
      sz = mq_d.size();
      fire = in_valid && (sz < 3);
      popped = 0;
      if (bit_take) begin
        if (mst == 0) begin
          mst = (sz > 0) ? 2 : 1; midx = 1;
        end else if (mst == 1) begin
          if (midx == 19) begin mst = 0; midx = 0; end else midx++;
        end else begin
          if (midx == mq_l[0] - 1) begin mst = 0; midx = 0; popped = 1; end
          else midx++;
        end
      end
      if (popped) begin void'(mq_d.pop_front()); void'(mq_l.pop_front()); end
      merr = 0;
      if (fire) begin
        if (ag < 15) begin acur[104 - 7*ag -: 7] = in_group; ag++; end
        else abad = 1;
        if (in_last) begin
          ok = !abad && ag >= 2 && (acur[104 -: 14] == 14'h3FFF);
          if (ok) begin mq_d.push_back(acur); mq_l.push_back(7*ag); end
          else merr = 1;
          acur = '0; ag = 0; abad = 0;
        end
      end
      if (popped) begin mdv = 1; mdc = mq_d.size(); end
      else if (done_ready) mdv = 0;
    end
  end

  function automatic bit exp_bit();
    if (mst == 1) return IDLE[19 - midx];
    if (mst == 2) return mq_d[0][104 - midx];
    return (mq_d.size() > 0) ? mq_d[0][104] : IDLE[19];
  endfunction

  always @(negedge clk) begin
    if (rst_n && started) begin
      bit eb;
      eb = exp_bit();
      if (!in_ready) saw_full = 1;
      if (pkt_err) errs_seen++;
      chk(in_ready == (mq_d.size() < 3), "R5 in_ready", in_ready, mq_d.size() < 3);
      if (mst == 2 || (mst == 0 && mq_d.size() > 0))
        chk(bit_data == eb, "R1/R2/R6 packet bit", bit_data, eb);
      else if (mq_d.size() > 0)
        chk(bit_data == eb, "R8 idle before packet", bit_data, eb);
      else
        chk(bit_data == eb, "R7 idle bit", bit_data, eb);
      chk(pkt_err == merr, "R3/R4 pkt_err", pkt_err, merr);
      chk(done_valid == mdv, "R9 done_valid", done_valid, mdv);
      if (mdv) chk(done_count == 2'(mdc), "R9 done_count", done_count, mdc);
    end
  end

  always @(negedge clk) begin
    tk_cnt++;
    case (take_mode)
      1:       bit_take = 1'b1;
      2:       bit_take = (tk_cnt % 3 == 0);
      default: bit_take = 1'b0;
    endcase
  end

  task automatic send(input int n, input logic [6:0] g0, input logic [6:0] g1, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_group = (k == 0) ? g0 : (k == 1) ? g1 : 7'(seed * 13 + k * 5 + 3);
      in_last  = (k == n - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);
    chk(done_valid == 1'b0, "R10 reset done_valid", done_valid, 0);
    chk(pkt_err == 1'b0, "R10 reset pkt_err", pkt_err, 0);
    chk(bit_data == 1'b1, "R7 first idle bit after reset", bit_data, 1);
    started = 1;
    take_mode = 1;
    repeat (50) @(negedge clk);
    send(3, 7'h7F, 7'h7F, 1);
    repeat (60) @(negedge clk);
    take_mode = 2;
    send(2, 7'h7F, 7'h7F, 2);
    send(5, 7'h7F, 7'h7F, 3);
    send(15, 7'h7F, 7'h7F, 4);
    send(3, 7'h7F, 7'h7F, 5);
    repeat (400) @(negedge clk);
    take_mode = 1;
    send(3, 7'h7F, 7'h7E, 6);   // broken lead-in: R3
    send(1, 7'h7F, 7'h7F, 7);   // single group: R3
    send(16, 7'h7F, 7'h7F, 8);  // sixteen groups: R4
    repeat (30) @(negedge clk);
    done_ready = 1'b0;
    send(2, 7'h7F, 7'h7F, 9);
    send(2, 7'h7F, 7'h7F, 10);
    repeat (80) @(negedge clk);
    done_ready = 1'b1;
    repeat (5) @(negedge clk);
    send(15, 7'h7F, 7'h7F, 11);
    repeat (40) @(negedge clk);
    take_mode = 0;
    repeat (20) @(negedge clk);
    take_mode = 1;
    repeat (300) @(negedge clk);
    chk(errs_seen == 3, "R3 R4 discarded packet count", errs_seen, 3);
    chk(saw_full == 1'b1, "R5 back-pressure seen", saw_full, 1);
    chk(in_ready == 1'b1, "R6 queue drained", in_ready, 1);
    summary();
  end
endmodule